// File: doc/BRIEF.md
# Split-Half Loadable Down-Counter

This block is a down-counter that can be cleared, loaded in parallel, and stepped down by one. It is built to reach high clock rates at widths of 20 to 32 bits. The count register is cut into a lower and an upper half. The borrow that moves the upper half is not rippled through the full width. It is kept in a flip-flop that records whether the lower half is currently zero. The flag is computed one cycle early from the value the lower half is about to take.

The decrement enable also comes straight from a flip-flop. The enable is computed as the registered run request ANDed with a lookahead nonzero flag, so no decision is made from combinational logic on the count. Callers load a start value from a wider bus and hold `run_i` high while counting is wanted. The counter stops by itself at zero and never wraps around.

Top module: `dcnt_split_top`

## Requirements
- R1: While `rst_n` is low, the outputs are `count_o` = 0, `nonzero_o` = 0 and `dec_en_o` = 0, and they take these values immediately without waiting for a clock edge.
- R2: A clock edge with `clr_i` high sets `count_o` to 0 and `dec_en_o` to 0. This holds whatever `load_i`, `run_i` and `dec_en_o` are doing.
- R3: A clock edge with `load_i` high and `clr_i` low copies `load_bus_i[CNT_W-1:0]` into `count_o`. Load takes priority over a pending decrement.
- R4: A clock edge with `dec_en_o` high and neither `clr_i` nor `load_i` high lowers `count_o` by exactly one. With `dec_en_o` low, the count holds.
- R5: Outside a clear, the value of `dec_en_o` after an edge equals `run_i` sampled at that edge, ANDed with the new count being nonzero. A decrement therefore starts one edge after `run_i` is seen.
- R6: `dec_en_o` is never high while `count_o` is 0. A count of 0 stays 0 until the next load.
- R7: `nonzero_o` equals (`count_o` != 0) in every cycle.
- R8: With the default `CNT_W` of 20, the lower half is bits 9:0. A decrement from a value whose lower half is 0 gives an upper half reduced by one and a lower half of all ones in the same edge. For example, 0x00400 steps to 0x003FF.
- R9: Bits of `load_bus_i` at position `CNT_W` and above have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously by the system |
| clr_i | input | 1 | Synchronous clear, highest priority |
| load_i | input | 1 | Parallel load strobe |
| load_bus_i | input | BUS_W | Load source; only the low CNT_W bits are used |
| run_i | input | 1 | Run request merging all external conditions for counting |
| count_o | output | CNT_W | Current count |
| nonzero_o | output | 1 | Registered flag, high when the count is nonzero |
| dec_en_o | output | 1 | Registered decrement enable |

## Verification
The assertions assume that `clr_i`, `load_i`, `run_i` and `load_bus_i` are synchronous to `clk` and stable around the rising edge. They also assume that `rst_n` is deasserted away from an edge. The bench drives every input on the falling edge and changes reset only between rising edges, so these assumptions hold. Stimulus covers loads of 0 and 1, values whose lower half is 0 or 1, and clears and loads that arrive while a decrement is pending.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_DEC  = 2'd1,
    OP_LOAD = 2'd2,
    OP_CLR  = 2'd3
  } dcnt_op_e;

  // Clear beats load, load beats decrement.
  function automatic dcnt_op_e pick_op(input logic clr, input logic ld, input logic dec);
    if (clr)      return OP_CLR;
    else if (ld)  return OP_LOAD;
    else if (dec) return OP_DEC;
    else          return OP_HOLD;
  endfunction

endpackage

// File: rtl/dcnt_lo_half.sv
module dcnt_lo_half
  import dcnt_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dcnt_op_e     op_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] val_o,
  output logic         borrow_o,
  output logic         is_one_o
);

  logic [W-1:0] val_q, val_d;
  logic         brw_q, brw_d;

  // Borrow flag holds "lower half is zero", computed from the next value.
  always_comb begin
    val_d = val_q;
    brw_d = brw_q;
    case (op_i)
      OP_CLR: begin
        val_d = '0;
        brw_d = 1'b1;
      end
      OP_LOAD: begin
        val_d = load_val_i;
        brw_d = (load_val_i == '0);
      end
      OP_DEC: begin
        val_d = val_q - 1'b1;
        brw_d = (val_q == W'(1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      brw_q <= 1'b1;
    end else begin
      val_q <= val_d;
      brw_q <= brw_d;
    end
  end

  assign val_o    = val_q;
  assign borrow_o = brw_q;
  assign is_one_o = (val_q == W'(1));

  AST_BORROW_TRACKS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    brw_q == (val_q == '0)); // R8

endmodule

// File: rtl/dcnt_hi_half.sv
module dcnt_hi_half
  import dcnt_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dcnt_op_e     op_i,
  input  logic         borrow_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] val_o,
  output logic         is_zero_o
);

  logic [W-1:0] val_q, val_d;
  logic         step;

  assign step = (op_i == OP_DEC) && borrow_i;

  always_comb begin
    val_d = val_q;
    case (op_i)
      OP_CLR:  val_d = '0;
      OP_LOAD: val_d = load_val_i;
      OP_DEC:  if (step) val_d = val_q - 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val_o     = val_q;
  assign is_zero_o = (val_q == '0);

  AST_HI_STEPS_ON_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (val_q == $past(val_q) - 1'b1)); // R8

  AST_HI_HOLDS_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_DEC && !borrow_i) |=> $stable(val_q)); // R8

endmodule

// File: rtl/dcnt_ctrl.sv
module dcnt_ctrl
  import dcnt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dcnt_op_e op_i,
  input  logic     run_i,
  input  logic     load_nz_i,
  input  logic     cnt_is_one_i,
  output logic     nz_o,
  output logic     en_o
);

  logic nz_q, nz_d;
  logic en_q, en_d;

  // Lookahead: nz_d is the nonzero state of the count after this edge.
  always_comb begin
    nz_d = nz_q;
    case (op_i)
      OP_CLR:  nz_d = 1'b0;
      OP_LOAD: nz_d = load_nz_i;
      OP_DEC:  nz_d = !cnt_is_one_i;
      default: ;
    endcase
    en_d = (op_i == OP_CLR) ? 1'b0 : (run_i && nz_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nz_q <= 1'b0;
      en_q <= 1'b0;
    end else begin
      nz_q <= nz_d;
      en_q <= en_d;
    end
  end

  assign nz_o = nz_q;
  assign en_o = en_q;

  AST_EN_NEEDS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> nz_q); // R6

endmodule

// File: rtl/dcnt_split_top.sv
module dcnt_split_top
  import dcnt_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [BUS_W-1:0] load_bus_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] count_o,
  output logic             nonzero_o,
  output logic             dec_en_o
);

  localparam int LO_W = CNT_W / 2;
  localparam int HI_W = CNT_W - LO_W;

  dcnt_op_e         op;
  logic [CNT_W-1:0] load_val;
  logic [LO_W-1:0]  lo_val;
  logic [HI_W-1:0]  hi_val;
  logic             lo_borrow, lo_one, hi_zero;
  logic             en_q, nz_q;

  assign load_val = load_bus_i[CNT_W-1:0];

  generate
    if (BUS_W > CNT_W) begin : g_wide_bus
      logic unused_upper_bits;
      assign unused_upper_bits = ^load_bus_i[BUS_W-1:CNT_W];
    end
  endgenerate

  assign op = pick_op(clr_i, load_i, en_q);

  dcnt_lo_half #(.W(LO_W)) u_lo (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op),
    .load_val_i (load_val[LO_W-1:0]),
    .val_o      (lo_val),
    .borrow_o   (lo_borrow),
    .is_one_o   (lo_one)
  );

  dcnt_hi_half #(.W(HI_W)) u_hi (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op),
    .borrow_i   (lo_borrow),
    .load_val_i (load_val[CNT_W-1:LO_W]),
    .val_o      (hi_val),
    .is_zero_o  (hi_zero)
  );

  dcnt_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op),
    .run_i        (run_i),
    .load_nz_i    (load_val != '0),
    .cnt_is_one_i (lo_one && hi_zero),
    .nz_o         (nz_q),
    .en_o         (en_q)
  );

  assign count_o   = {hi_val, lo_val};
  assign nonzero_o = nz_q;
  assign dec_en_o  = en_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0 && !dec_en_o)); // R2

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && load_i) |=> (count_o == $past(load_bus_i[CNT_W-1:0]))); // R3

  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_i && dec_en_o) |=> (count_o == $past(count_o) - 1'b1)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_i && !dec_en_o) |=> $stable(count_o)); // R4

  AST_EN_FOLLOWS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (dec_en_o == ($past(run_i) && count_o != '0))); // R5

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0 && !load_i) |=> (count_o == '0)); // R6

  AST_NZ_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    nonzero_o == (count_o != '0)); // R7

endmodule

// File: tb/test_dcnt_split_top.sv
module test_dcnt_split_top;

  localparam int CW = 20;
  localparam int BW = 32;

  typedef struct packed {
    logic          clr;
    logic          ld;
    logic          run;
    logic [BW-1:0] bus;
    logic [CW-1:0] cnt;
    logic          nz;
    logic          en;
  } vec_t;

  // Each row: inputs applied for one edge, then outputs expected after it.
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 32'hFFF0_0402, 20'h00402, 1'b1, 1'b1}, // R3 R9
    '{1'b0, 1'b0, 1'b1, 32'h0,         20'h00401, 1'b1, 1'b1}, // R4
    '{1'b0, 1'b0, 1'b1, 32'h0,         20'h00400, 1'b1, 1'b1},
    '{1'b0, 1'b0, 1'b1, 32'h0,         20'h003FF, 1'b1, 1'b1}, // R8
    '{1'b0, 1'b0, 1'b0, 32'h0,         20'h003FE, 1'b1, 1'b0}, // R5
    '{1'b0, 1'b0, 1'b0, 32'h0,         20'h003FE, 1'b1, 1'b0}, // R4 hold
    '{1'b0, 1'b0, 1'b1, 32'h0,         20'h003FE, 1'b1, 1'b1}, // R5
    '{1'b0, 1'b1, 1'b1, 32'h0000_0001, 20'h00001, 1'b1, 1'b1}, // R3 over dec
    '{1'b0, 1'b0, 1'b1, 32'h0,         20'h00000, 1'b0, 1'b0}, // R6
    '{1'b0, 1'b0, 1'b1, 32'h0,         20'h00000, 1'b0, 1'b0}, // R6
    '{1'b0, 1'b1, 1'b1, 32'h0000_0000, 20'h00000, 1'b0, 1'b0}, // load 0
    '{1'b0, 1'b1, 1'b1, 32'h0000_0C01, 20'h00C01, 1'b1, 1'b1}, // low half 1
    '{1'b0, 1'b0, 1'b1, 32'h0,         20'h00C00, 1'b1, 1'b1},
    '{1'b1, 1'b1, 1'b1, 32'h0000_0005, 20'h00000, 1'b0, 1'b0}, // R2
    '{1'b0, 1'b1, 1'b1, 32'h000A_BCDE, 20'hABCDE, 1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b1, 32'h0,         20'h00000, 1'b0, 1'b0}  // R2
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr_i, load_i, run_i;
  logic [BW-1:0] load_bus_i;
  logic [CW-1:0] count_o;
  logic          nonzero_o, dec_en_o;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  logic [CW-1:0] m_cnt;
  logic          m_en;

  always #2 clk = ~clk;

  dcnt_split_top #(.CNT_W(CW), .BUS_W(BW)) i_dcnt_split_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .load_i     (load_i),
    .load_bus_i (load_bus_i),
    .run_i      (run_i),
    .count_o    (count_o),
    .nonzero_o  (nonzero_o),
    .dec_en_o   (dec_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Drive on a falling edge, pass one rising edge, return at the next falling edge.
  task automatic step(input logic c, input logic l, input logic r, input logic [BW-1:0] b);
    clr_i = c; load_i = l; run_i = r; load_bus_i = b;
    @(posedge clk);
    if (c) begin
      m_cnt = '0; m_en = 1'b0;
    end else begin
      if (l)         m_cnt = b[CW-1:0];
      else if (m_en) m_cnt = m_cnt - 1'b1;
      m_en = r && (m_cnt != '0);
    end
    @(negedge clk);
  endtask

  task automatic chk_model(input string tag);
    chk({tag, " count R4"}, 32'(count_o), 32'(m_cnt));
    chk({tag, " nz R7"},    32'(nonzero_o), 32'(m_cnt != '0));
    chk({tag, " en R5"},    32'(dec_en_o), 32'(m_en));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr_i = 1'b0; load_i = 1'b0; run_i = 1'b0; load_bus_i = '0;
    m_cnt = '0; m_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("reset count R1", 32'(count_o), 32'h0);
    chk("reset nz R1",    32'(nonzero_o), 32'h0);
    chk("reset en R1",    32'(dec_en_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].clr, VECS[i].ld, VECS[i].run, VECS[i].bus);
      chk($sformatf("vec%0d count R3 R4 R8 R9", i), 32'(count_o), 32'(VECS[i].cnt));
      chk($sformatf("vec%0d nz R7", i),            32'(nonzero_o), 32'(VECS[i].nz));
      chk($sformatf("vec%0d en R5 R6", i),         32'(dec_en_o), 32'(VECS[i].en));
    end

    // Borrow from a lower half of zero with a large upper half: R8
    step(1'b0, 1'b1, 1'b1, 32'h0005_5000);
    step(1'b0, 1'b0, 1'b1, 32'h0);
    chk("borrow R8", 32'(count_o), 32'h54FFF);
    chk_model("borrow");

    // Asynchronous reset in the middle of a countdown: R1
    step(1'b0, 1'b1, 1'b1, 32'h0000_0123);
    step(1'b0, 1'b0, 1'b1, 32'h0);
    #1 rst_n = 1'b0;
    #0.5;
    chk("async count R1", 32'(count_o), 32'h0);
    chk("async nz R1",    32'(nonzero_o), 32'h0);
    chk("async en R1",    32'(dec_en_o), 32'h0);
    m_cnt = '0; m_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Load 1 then run down: stop at zero, R6
    step(1'b0, 1'b1, 1'b1, 32'h0000_0001);
    step(1'b0, 1'b0, 1'b1, 32'h0);
    step(1'b0, 1'b0, 1'b1, 32'h0);
    chk("stop R6", 32'(count_o), 32'h0);
    chk("stop en R6", 32'(dec_en_o), 32'h0);

    // Random traffic against the reference model
    for (int k = 0; k < 3000; k++) begin
      logic          c, l, r;
      logic [BW-1:0] b;
      int            sel;
      c   = ($urandom % 32) == 0;
      l   = ($urandom % 8) == 0;
      r   = ($urandom % 4) != 0;
      sel = $urandom % 8;
      if (sel < 3)       b = 32'($urandom % 4) | ({$urandom} & 32'hFFF0_0000);
      else if (sel == 3) b = {$urandom} & 32'hFFFF_FC00;
      else if (sel == 4) b = ({$urandom} & 32'hFFFF_FC00) | 32'h1;
      else if (sel == 5) b = 32'($urandom % 2048);
      else               b = $urandom;
      step(c, l, r, b);
      chk_model("random R2 R3 R6 R8");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

endmodule